// File: doc/BRIEF.md
# CPU Interrupt Pending and Mask Unit

This unit holds three 32-bit words for a single processor. The first is a private pending word. The second is a copy of the floating pending word that all processors share. The third is an enable mask. The unit combines the three into an interrupt request and a set of per-class "open" indications, where open means both pending and enabled.

Interrupt sources set and clear pending bits through per-bit strobes. Each mask subfield is rebuilt from the program-status mask bits and from the external, PER and machine-check control-register images whenever `mask_load_i` is pulsed. Five mask bits are permanently enabled.

PER events are special in two ways. A PER event is only recorded when its mask bit is already set. Once recorded, it bypasses the mask when the request is evaluated. In guest mode, only a small set of floating bits contribute to the request.

The unit does not select which interrupt to take, and it does not run any handler sequence.

Top module: `cpu_irq_unit`

## Requirements

Bit map used by every requirement:

| Bit(s) | Meaning |
|---|---|
| 31 | debug |
| 30 | not-started |
| 29 | I/O |
| 28..24 | machine-check field |
| 23..19 | PER field |
| 15..9 and 7..4 | external field, mask 0x0000FEF0; 11 is clock comparator, 10 is CPU timer, 7 is interval timer |
| 3 | store-status |
| 2 | broadcast |
| 1 | restart |
| 0 | wait |

`sysmask_i` bit 0 is external enable. `sysmask_i` bit 1 is the I/O enable in extended mode.

- R1: After reset the following hold: local pending = 0; floating pending = 0x00000001; `mask_o` = 0xC000000E; `irq_req_o` = 0; `dis_wait_o` = 1.
- R2: On `mask_load_i`, the external field of the mask becomes `cr0_i` & 0x0000FEF0 if `sysmask_i[0]` is 1, and 0 otherwise.
- R3: On `mask_load_i`, the machine-check field becomes `cr14_i` & 0x1F000000 if `psw_mck_en_i` is 1, and 0 otherwise.
- R4: On `mask_load_i`, the PER field becomes (`cr9_i` >> 8) & 0x00F80000 if `per_mode_i` is 1, and 0 otherwise.
- R5: On `mask_load_i`, the I/O mask bit is set as follows:
  - with `ec_mode_i` = 0, it is the OR of `sysmask_i[7:1]`;
  - with `ec_mode_i` = 1, it equals `sysmask_i[1]`.
  The wait mask bit equals `psw_wait_i`.
- R6: A local set strobe on a PER bit records that bit only if the same mask bit is already 1.
- R7: `open_o` = (local | floating) & (`mask_o` | 0x00F80000), and `irq_req_o` is the OR of `open_o`. Recorded PER bits therefore stay open after PER mode is turned off.
- R8: With `guest_i` = 1, the only floating bits that take part are bits 29, 11, 10, 7 and 2.
- R9: `dis_wait_o` is 1 exactly when the mask has no bit set in the I/O, external or machine-check fields.
- R10: Set and clear strobes act at the next rising edge. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: The mask changes only on `mask_load_i`. Bits 31, 30, 3, 2 and 1 of the mask stay 1 at all times.
- R12: `open_io_o`, `open_ext_o`, `open_mck_o` and `open_per_o` are the OR of `open_o` over the I/O bit, the external field, the machine-check field and the PER field respectively.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_load_i | input | 1 | Rebuild the mask from the status and control inputs |
| psw_mck_en_i | input | 1 | Machine-check enable from the status word |
| per_mode_i | input | 1 | PER mode active |
| ec_mode_i | input | 1 | 1 = extended-control mode, 0 = basic-control mode |
| psw_wait_i | input | 1 | Status-word wait bit |
| sysmask_i | input | 8 | System mask byte |
| cr0_i | input | 32 | External-subclass control image |
| cr9_i | input | 32 | PER control image |
| cr14_i | input | 32 | Machine-check control image |
| loc_set_i | input | 32 | Per-bit set strobes, local word |
| loc_clr_i | input | 32 | Per-bit clear strobes, local word |
| flt_set_i | input | 32 | Per-bit set strobes, floating word |
| flt_clr_i | input | 32 | Per-bit clear strobes, floating word |
| guest_i | input | 1 | Guest-mode filtering of the floating word |
| irq_req_o | output | 1 | Some interrupt is pending and enabled |
| dis_wait_o | output | 1 | No maskable class is enabled |
| mask_o | output | 32 | Current mask word |
| open_o | output | 32 | Per-bit pending-and-enabled vector |
| open_io_o | output | 1 | I/O open |
| open_ext_o | output | 1 | Some external subclass is open |
| open_mck_o | output | 1 | Some machine-check subclass is open |
| open_per_o | output | 1 | Some PER event is open |

## Verification

The bench targets the corner cases below, each with the failure it would expose:

- **PER gating.** A design that records PER events without consulting the mask would pick up bits the program never enabled.
- **PER bypass.** A design that applies the mask to recorded PER bits would drop the request as soon as PER mode is cleared.
- **I/O bit in basic-control mode.** A design that ignored the mode would enable I/O from the lone external-enable bit, or miss the high bits of the system mask.
- **Guest filter.** A design with a wrong filter would raise a request for a floating external call while in guest mode.
- **Set against clear in the same cycle.** A design where clear wins would lose the event.
- **Mask loading.** A design that let the mask follow the control inputs without a load would change enables unannounced.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t IO_BIT     = 32'h2000_0000;
  localparam word_t MCK_BITS   = 32'h1F00_0000;
  localparam word_t PER_BITS   = 32'h00F8_0000;
  localparam word_t EXT_BITS   = 32'h0000_FEF0;
  localparam word_t WAIT_BIT   = 32'h0000_0001;
  localparam word_t FIXED_MASK = 32'hC000_000E;
  localparam word_t FLT_RESET  = 32'h0000_0001;
  // broadcast, I/O, clock comparator, CPU timer, interval timer
  localparam word_t GUEST_BITS = 32'h2000_0C84;
  localparam word_t OPEN_CLASS = IO_BIT | EXT_BITS | MCK_BITS;

  typedef struct packed {
    logic       mck_en;
    logic       per_mode;
    logic       ec_mode;
    logic       wait_st;
    logic [7:0] sysmask;
  } psw_ctl_t;
endpackage

// File: rtl/cpu_irq_mask_reg.sv
module cpu_irq_mask_reg
  import cpu_irq_pkg::*;
#(
  parameter int unsigned PER_SHIFT = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  psw_ctl_t psw_i,
  input  word_t    cr0_i,
  input  word_t    cr9_i,
  input  word_t    cr14_i,
  output word_t    mask_o
);
  localparam int unsigned IO_POS = 29;
  localparam int unsigned EXT_EN = 0;
  localparam int unsigned EC_IO  = 1;

  word_t mask_q, mask_d;
  logic  io_en;

  always_comb begin
    io_en = psw_i.ec_mode ? psw_i.sysmask[EC_IO] : |psw_i.sysmask[7:1];
    mask_d = FIXED_MASK;
    if (psw_i.sysmask[EXT_EN]) mask_d |= cr0_i & EXT_BITS;
    if (psw_i.mck_en)          mask_d |= cr14_i & MCK_BITS;
    if (psw_i.per_mode)        mask_d |= (cr9_i >> PER_SHIFT) & PER_BITS;
    mask_d[IO_POS] = io_en;
    mask_d[0]      = psw_i.wait_st;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= FIXED_MASK;
    else if (load_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/cpu_irq_state_word.sv
module cpu_irq_state_word
  import cpu_irq_pkg::*;
#(
  parameter word_t RESET_VAL = '0,
  parameter bit    GATE_PER  = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t set_i,
  input  word_t clr_i,
  input  word_t mask_i,
  output word_t state_o
);
  word_t state_q, set_eff;

  generate
    if (GATE_PER) begin : g_gate
      assign set_eff = set_i & (~PER_BITS | mask_i);
    end else begin : g_nogate
      assign set_eff = set_i;
    end
  endgenerate

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RESET_VAL;
    else         state_q <= (state_q & ~clr_i) | set_eff;
  end

  assign state_o = state_q;
endmodule

// File: rtl/cpu_irq_eval.sv
module cpu_irq_eval
  import cpu_irq_pkg::*;
(
  input  word_t loc_i,
  input  word_t flt_i,
  input  word_t mask_i,
  input  logic  guest_i,
  output word_t open_o,
  output logic  req_o,
  output logic  dis_wait_o,
  output logic  open_io_o,
  output logic  open_ext_o,
  output logic  open_mck_o,
  output logic  open_per_o
);
  word_t flt_eff;

  always_comb begin
    flt_eff    = guest_i ? (flt_i & GUEST_BITS) : flt_i;
    open_o     = (loc_i | flt_eff) & (mask_i | PER_BITS);
    req_o      = |open_o;
    dis_wait_o = ~|(mask_i & OPEN_CLASS);
    open_io_o  = |(open_o & IO_BIT);
    open_ext_o = |(open_o & EXT_BITS);
    open_mck_o = |(open_o & MCK_BITS);
    open_per_o = |(open_o & PER_BITS);
  end
endmodule

// File: rtl/cpu_irq_unit.sv
module cpu_irq_unit
  import cpu_irq_pkg::*;
#(
  parameter int unsigned PER_SHIFT = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mask_load_i,
  input  logic        psw_mck_en_i,
  input  logic        per_mode_i,
  input  logic        ec_mode_i,
  input  logic        psw_wait_i,
  input  logic [7:0]  sysmask_i,
  input  logic [31:0] cr0_i,
  input  logic [31:0] cr9_i,
  input  logic [31:0] cr14_i,
  input  logic [31:0] loc_set_i,
  input  logic [31:0] loc_clr_i,
  input  logic [31:0] flt_set_i,
  input  logic [31:0] flt_clr_i,
  input  logic        guest_i,
  output logic        irq_req_o,
  output logic        dis_wait_o,
  output logic [31:0] mask_o,
  output logic [31:0] open_o,
  output logic        open_io_o,
  output logic        open_ext_o,
  output logic        open_mck_o,
  output logic        open_per_o
);
  psw_ctl_t psw;
  word_t    mask_q, loc_q, flt_q;

  assign psw = '{mck_en: psw_mck_en_i, per_mode: per_mode_i, ec_mode: ec_mode_i,
                 wait_st: psw_wait_i, sysmask: sysmask_i};

  cpu_irq_mask_reg #(.PER_SHIFT(PER_SHIFT)) u_mask (
    .clk_i, .rst_ni, .load_i(mask_load_i), .psw_i(psw),
    .cr0_i, .cr9_i, .cr14_i, .mask_o(mask_q)
  );

  cpu_irq_state_word #(.RESET_VAL('0), .GATE_PER(1'b1)) u_loc (
    .clk_i, .rst_ni, .set_i(loc_set_i), .clr_i(loc_clr_i),
    .mask_i(mask_q), .state_o(loc_q)
  );

  cpu_irq_state_word #(.RESET_VAL(FLT_RESET), .GATE_PER(1'b0)) u_flt (
    .clk_i, .rst_ni, .set_i(flt_set_i), .clr_i(flt_clr_i),
    .mask_i(mask_q), .state_o(flt_q)
  );

  cpu_irq_eval u_eval (
    .loc_i(loc_q), .flt_i(flt_q), .mask_i(mask_q), .guest_i,
    .open_o, .req_o(irq_req_o), .dis_wait_o,
    .open_io_o, .open_ext_o, .open_mck_o, .open_per_o
  );

  assign mask_o = mask_q;
endmodule

// File: rtl/cpu_irq_unit_chk.sv
module cpu_irq_unit_chk
  import cpu_irq_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  mask_load_i,
  input logic  guest_i,
  input word_t loc_set_i,
  input word_t loc_clr_i,
  input word_t loc_q,
  input word_t flt_q,
  input word_t mask_q,
  input logic  irq_req_o,
  input logic  dis_wait_o,
  input logic  open_io_o,
  input logic  open_ext_o,
  input logic  open_mck_o
);
  a_r6_per_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((loc_q & ~$past(loc_q) & PER_BITS & ~$past(mask_q)) == '0));

  a_r7_req_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> ((loc_q | flt_q) != '0));

  a_r8_guest_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guest_i && loc_q == '0 && (flt_q & GUEST_BITS) == '0) |-> !irq_req_o);

  a_r9_dis_wait_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_wait_o |-> !(open_io_o || open_ext_o || open_mck_o));

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((loc_set_i & loc_clr_i & ~PER_BITS) != '0) |=>
      ((loc_q & $past(loc_set_i & loc_clr_i & ~PER_BITS))
        == $past(loc_set_i & loc_clr_i & ~PER_BITS)));

  a_r11_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_load_i |=> $stable(mask_q));

  a_r11_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & FIXED_MASK) == FIXED_MASK);
endmodule

bind cpu_irq_unit cpu_irq_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mask_load_i(mask_load_i), .guest_i(guest_i),
  .loc_set_i(loc_set_i), .loc_clr_i(loc_clr_i), .loc_q(loc_q), .flt_q(flt_q),
  .mask_q(mask_q), .irq_req_o(irq_req_o), .dis_wait_o(dis_wait_o),
  .open_io_o(open_io_o), .open_ext_o(open_ext_o), .open_mck_o(open_mck_o)
);

// File: tb/cpu_irq_unit_tb.sv
module cpu_irq_unit_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_ni = 0;
  logic mask_load_i = 0, psw_mck_en_i = 0, per_mode_i = 0, ec_mode_i = 0, psw_wait_i = 0;
  logic [7:0]  sysmask_i = '0;
  logic [31:0] cr0_i = '0, cr9_i = '0, cr14_i = '0;
  logic [31:0] loc_set_i = '0, loc_clr_i = '0, flt_set_i = '0, flt_clr_i = '0;
  logic guest_i = 0;
  logic irq_req_o, dis_wait_o, open_io_o, open_ext_o, open_mck_o, open_per_o;
  logic [31:0] mask_o, open_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cpu_irq_unit u_dut (
    .clk_i(clk), .rst_ni, .mask_load_i, .psw_mck_en_i, .per_mode_i, .ec_mode_i,
    .psw_wait_i, .sysmask_i, .cr0_i, .cr9_i, .cr14_i, .loc_set_i, .loc_clr_i,
    .flt_set_i, .flt_clr_i, .guest_i, .irq_req_o, .dis_wait_o, .mask_o, .open_o,
    .open_io_o, .open_ext_o, .open_mck_o, .open_per_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_mask(logic mck, logic per, logic ec, logic wt, logic [7:0] sm,
                           logic [31:0] c0, logic [31:0] c9, logic [31:0] c14);
    @(negedge clk);
    psw_mck_en_i = mck; per_mode_i = per; ec_mode_i = ec; psw_wait_i = wt;
    sysmask_i = sm; cr0_i = c0; cr9_i = c9; cr14_i = c14; mask_load_i = 1;
    @(negedge clk);
    mask_load_i = 0;
  endtask

  task automatic pulse_loc(logic [31:0] s, logic [31:0] c);
    @(negedge clk); loc_set_i = s; loc_clr_i = c;
    @(negedge clk); loc_set_i = '0; loc_clr_i = '0;
  endtask

  task automatic pulse_flt(logic [31:0] s, logic [31:0] c);
    @(negedge clk); flt_set_i = s; flt_clr_i = c;
    @(negedge clk); flt_set_i = '0; flt_clr_i = '0;
  endtask

  task automatic t_reset;
    chk("R1 mask", mask_o, 32'hC000_000E);
    chk("R1 req", irq_req_o, 0);
    chk("R9 dis_wait reset", dis_wait_o, 1);
    load_mask(0, 0, 0, 1, 8'h00, 0, 0, 0);
    chk("R5 wait mask", mask_o, 32'hC000_000F);
    chk("R1 floating wait", open_o, 32'h1);
    pulse_flt(0, 32'h1);
    chk("R1 floating cleared", irq_req_o, 0);
  endtask

  task automatic t_ext_mck;
    load_mask(0, 0, 0, 0, 8'h01, 32'hFFFF_FFFF, 0, 0);
    chk("R2 ext on", mask_o, 32'hC000_FEFE);
    chk("R9 ext enabled", dis_wait_o, 0);
    load_mask(0, 0, 0, 0, 8'h00, 32'hFFFF_FFFF, 0, 0);
    chk("R2 ext off", mask_o, 32'hC000_000E);
    load_mask(1, 0, 0, 0, 8'h00, 0, 0, 32'hFFFF_FFFF);
    chk("R3 mck on", mask_o, 32'hDF00_000E);
    load_mask(0, 0, 0, 0, 8'h00, 0, 0, 32'hFFFF_FFFF);
    chk("R3 mck off", mask_o, 32'hC000_000E);
  endtask

  task automatic t_per_io;
    load_mask(0, 1, 0, 0, 8'h00, 0, 32'hF800_0000, 0);
    chk("R4 per field", mask_o, 32'hC0F8_000E);
    chk("R9 per not a class", dis_wait_o, 1);
    load_mask(0, 1, 0, 0, 8'h00, 0, 32'h00F8_0000, 0);
    chk("R4 shift drops", mask_o, 32'hC000_000E);
    load_mask(0, 0, 0, 0, 8'h00, 0, 32'hF800_0000, 0);
    chk("R4 per mode off", mask_o, 32'hC000_000E);
    load_mask(0, 0, 0, 0, 8'h80, 0, 0, 0);
    chk("R5 bc io", mask_o, 32'hE000_000E);
    load_mask(0, 0, 0, 0, 8'h01, 0, 0, 0);
    chk("R5 bc bit0 no io", mask_o, 32'hC000_000E);
    load_mask(0, 0, 1, 0, 8'h02, 0, 0, 0);
    chk("R5 ec io", mask_o, 32'hE000_000E);
    load_mask(0, 0, 1, 0, 8'hFD, 0, 0, 0);
    chk("R5 ec io off", mask_o, 32'hC000_000E);
  endtask

  task automatic t_per_gate;
    load_mask(0, 1, 0, 0, 8'h00, 0, 32'h8000_0000, 0);
    pulse_loc(32'h00F8_0000, 0);
    chk("R6 per gated", open_o, 32'h0080_0000);
    chk("R12 open_per", open_per_o, 1);
    load_mask(0, 0, 0, 0, 8'h00, 0, 0, 0);
    chk("R7 per bypass", open_o, 32'h0080_0000);
    chk("R7 per bypass req", irq_req_o, 1);
    pulse_loc(0, 32'h00F8_0000);
    chk("R7 cleared", irq_req_o, 0);
  endtask

  task automatic t_request;
    pulse_loc(32'h0000_0800, 0);
    chk("R7 masked pending", irq_req_o, 0);
    load_mask(0, 0, 0, 0, 8'h01, 32'h0000_0800, 0, 0);
    chk("R7 enabled", irq_req_o, 1);
    chk("R12 open_ext", open_ext_o, 1);
    @(negedge clk); cr0_i = '0;
    @(negedge clk);
    chk("R11 no load", mask_o, 32'hC000_080E);
    pulse_loc(0, 32'h0000_0800);
    chk("R7 req drops", irq_req_o, 0);
  endtask

  task automatic t_guest;
    load_mask(0, 0, 0, 0, 8'h01, 32'hFFFF_FFFF, 0, 0);
    pulse_flt(32'h0000_2000, 0);
    chk("R8 host sees extcall", irq_req_o, 1);
    @(negedge clk); guest_i = 1; #1;
    chk("R8 guest filters extcall", irq_req_o, 0);
    pulse_flt(32'h0000_0800, 32'h0000_2000);
    chk("R8 guest clock comparator", open_o, 32'h0000_0800);
    @(negedge clk); guest_i = 0;
    pulse_flt(0, 32'h0000_0800);
  endtask

  task automatic t_set_clear;
    load_mask(0, 0, 0, 0, 8'h01, 32'h0000_0400, 0, 0);
    @(negedge clk); loc_set_i = 32'h400; loc_clr_i = 32'h400;
    #1 chk("R10 before edge", irq_req_o, 0);
    @(negedge clk); loc_set_i = '0; loc_clr_i = '0;
    chk("R10 set wins", open_o, 32'h400);
    pulse_loc(0, 32'h400);
    chk("R10 clear", open_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_ext_mck();
    t_per_io();
    t_per_gate();
    t_request();
    t_guest();
    t_set_clear();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule